// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Flush and Invalidate

This block caches recent translations from virtual page numbers to physical page numbers. A requester presents a virtual page number; the block compares it against every valid entry at once and, when one matches, returns the physical page number, the read/write/execute permission bits and the dirty bit in the same cycle, with no table access. When nothing matches, the block reports a miss and enters a walking state. The requester then walks the page tables itself and hands back the resulting entry as a refill. Afterwards it retries the access.

Two maintenance inputs keep the cached translations consistent with memory. Writing the page table base (a context switch) clears every valid bit and abandons any walk in progress. Changing a table entry invalidates the one cached translation for that virtual page. The block never writes anything back to memory. A refill goes to the entry that already holds the same virtual page if there is one. Otherwise it goes to the lowest-numbered invalid entry, and when every entry is valid it evicts the least recently used one. Both hits and refills count as uses.

The control is a two-state machine. `S_READY` means no walk is outstanding. The transition *miss_start* moves to `S_WALK` when a lookup misses. `S_WALK` means a walk is outstanding. From there, *fill_done* returns to `S_READY` when a refill is taken, and *flush_abort* returns to `S_READY` when the base is written. Lookups are answered in both states.

Top module: `tlb_fa`

## Requirements
- R1: A lookup with `lk_valid` high whose `lk_vpn` equals the tag of a valid entry raises `lk_hit` combinationally in that cycle and drives that entry's `lk_ppn`, `lk_perm` (bit 2 read, bit 1 write, bit 0 execute) and `lk_dirty`.
- R2: A lookup that finds no valid matching entry raises `lk_miss` and not `lk_hit`; if `walk_busy` is low, `walk_busy` is high from the next cycle (transition miss_start).
- R3: A refill (`fill_valid`) is taken only while `walk_busy` is high, and taking it clears `walk_busy` on the next cycle (fill_done); a refill presented while `walk_busy` is low is ignored and leaves the stored translations unchanged.
- R4: A taken refill is written into the valid entry already holding `fill_vpn` if one exists, else into the lowest-indexed invalid entry, else into the least recently used entry.
- R5: Recency is updated by every taken refill (to the filled entry) and by every hit in a cycle without a taken refill.
- R6: A cycle with `base_wr` high invalidates every entry from the next cycle, and if `walk_busy` was high it drops to low (flush_abort).
- R7: A cycle with `inv_valid` high invalidates only the entry holding `inv_vpn`; all other entries keep hitting.
- R8: A lookup in the same cycle as `base_wr` or `inv_valid` reports a miss, whether or not a matching entry exists.
- R9: A refill in the same cycle as `base_wr` or `inv_valid` is not taken: nothing is written and a walk still pending stays pending unless the base write aborts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Translation found this cycle |
| lk_miss | output | 1 | Lookup requested and not found |
| lk_ppn | output | PPN_W | Physical page number on a hit, zero otherwise |
| lk_perm | output | 3 | Read, write, execute bits on a hit |
| lk_dirty | output | 1 | Dirty bit on a hit |
| walk_busy | output | 1 | A miss is waiting for its refill (state S_WALK) |
| fill_valid | input | 1 | Refill entry presented |
| fill_vpn | input | VPN_W | Virtual page number of the refill |
| fill_ppn | input | PPN_W | Physical page number of the refill |
| fill_perm | input | 3 | Permission bits of the refill |
| fill_dirty | input | 1 | Dirty bit of the refill |
| base_wr | input | 1 | Page table base written: flush all entries |
| inv_valid | input | 1 | Invalidate one translation |
| inv_vpn | input | VPN_W | Virtual page number to invalidate |

## Verification
The properties assume the requester keeps to the protocol. The maintenance inputs stay low while reset is asserted. At most one entry can match any key, which holds only because every refill goes through the duplicate check. The bench drives every input at the falling edge and holds the maintenance inputs low during reset. It uses a four-entry configuration with a five-bit page number, so a sweep reaches every virtual page and forces repeated eviction. Refills are also presented outside a walk, and alongside flushes and invalidates, so the ignore rules are exercised against a reference model that tracks recency with timestamps.

// File: rtl/tlb_fa_pkg.sv
package tlb_fa_pkg;
    typedef enum logic {
        S_READY = 1'b0,
        S_WALK  = 1'b1
    } walk_state_t;

    localparam int PERM_W = 3;
endpackage

// File: rtl/tlb_fa_match.sv
module tlb_fa_match #(
    parameter int N  = 64,
    parameter int KW = 20,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         valid_vec,
    input  logic [N-1:0][KW-1:0] tag_arr,
    input  logic [KW-1:0]        key,
    output logic [N-1:0]         hit_vec,
    output logic [IW-1:0]        hit_idx
);
    // one comparator per entry
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid_vec[g] && (tag_arr[g] == key);
    end

    // encode: lowest matching index wins (at most one matches in practice)
    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IW'(i);
        end
    end
endmodule

// File: rtl/tlb_fa_lru.sv
module tlb_fa_lru #(
    parameter int N = 64,
    localparam int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_en,
    input  logic [AW-1:0] touch_idx,
    input  logic [N-1:0]  valid_vec,
    output logic [AW-1:0] victim_idx
);
    // ages form a permutation of 0..N-1; 0 is most recent
    logic [AW-1:0] ages [N];
    logic [AW-1:0] inv_idx;
    logic [AW-1:0] old_idx;
    logic          have_inv;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) ages[i] <= AW'(i);
        end else if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (AW'(i) == touch_idx)
                    ages[i] <= '0;
                else if (ages[i] < ages[touch_idx])
                    ages[i] <= ages[i] + 1'b1;
            end
        end
    end

    always_comb begin
        inv_idx  = '0;
        have_inv = 1'b0;
        old_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                inv_idx  = AW'(i);
                have_inv = 1'b1;
            end
            if (ages[i] == AW'(N - 1)) old_idx = AW'(i);
        end
        victim_idx = have_inv ? inv_idx : old_idx;
    end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_fa_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [2:0]       lk_perm,
    output logic             lk_dirty,
    output logic             walk_busy,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [2:0]       fill_perm,
    input  logic             fill_dirty,
    input  logic             base_wr,
    input  logic             inv_valid,
    input  logic [VPN_W-1:0] inv_vpn
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    walk_state_t state, state_nx;

    logic [ENTRIES-1:0]                   ent_valid;
    logic [ENTRIES-1:0][VPN_W-1:0]        ent_vpn;
    logic [ENTRIES-1:0][PPN_W-1:0]        ent_ppn;
    logic [ENTRIES-1:0][PERM_W-1:0]       ent_perm;
    logic [ENTRIES-1:0]                   ent_dirty;

    logic [ENTRIES-1:0] lk_hit_vec, mt_hit_vec;
    logic [IW-1:0]      lk_idx, mt_idx, victim_idx, fill_slot, touch_idx;
    logic [VPN_W-1:0]   mt_key;
    logic               lk_found, mt_found, maint_now, fill_take, touch_en;

    // lookup comparator bank
    tlb_fa_match #(.N(ENTRIES), .KW(VPN_W)) u_lk_match (
        .valid_vec (ent_valid),
        .tag_arr   (ent_vpn),
        .key       (lk_vpn),
        .hit_vec   (lk_hit_vec),
        .hit_idx   (lk_idx)
    );

    // maintenance comparator bank: invalidate key, else refill key
    assign mt_key = inv_valid ? inv_vpn : fill_vpn;

    tlb_fa_match #(.N(ENTRIES), .KW(VPN_W)) u_mt_match (
        .valid_vec (ent_valid),
        .tag_arr   (ent_vpn),
        .key       (mt_key),
        .hit_vec   (mt_hit_vec),
        .hit_idx   (mt_idx)
    );

    assign lk_found  = |lk_hit_vec;
    assign mt_found  = |mt_hit_vec;
    assign maint_now = base_wr || inv_valid;
    assign fill_take = (state == S_WALK) && fill_valid && !maint_now;
    assign fill_slot = mt_found ? mt_idx : victim_idx;

    // recency: refill wins over a hit in the same cycle
    always_comb begin
        touch_en  = fill_take || lk_hit;
        touch_idx = fill_take ? fill_slot : lk_idx;
    end

    tlb_fa_lru #(.N(ENTRIES)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .valid_vec  (ent_valid),
        .victim_idx (victim_idx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_READY;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_READY: if (lk_miss)       state_nx = S_WALK;   // miss_start
            S_WALK: begin
                if (base_wr)            state_nx = S_READY;  // flush_abort
                else if (fill_take)     state_nx = S_READY;  // fill_done
            end
            default:                    state_nx = S_READY;
        endcase
    end

    // outputs
    always_comb begin
        lk_hit    = lk_valid && lk_found && !maint_now;
        lk_miss   = lk_valid && !lk_hit;
        walk_busy = (state == S_WALK);
        lk_ppn    = '0;
        lk_perm   = '0;
        lk_dirty  = 1'b0;
        if (lk_hit) begin
            lk_ppn   = ent_ppn[lk_idx];
            lk_perm  = ent_perm[lk_idx];
            lk_dirty = ent_dirty[lk_idx];
        end
    end

    // entry storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_vpn   <= '0;
            ent_ppn   <= '0;
            ent_perm  <= '0;
            ent_dirty <= '0;
        end else if (base_wr) begin
            ent_valid <= '0;
        end else if (inv_valid) begin
            ent_valid <= ent_valid & ~mt_hit_vec;
        end else if (fill_take) begin
            ent_valid[fill_slot] <= 1'b1;
            ent_vpn[fill_slot]   <= fill_vpn;
            ent_ppn[fill_slot]   <= fill_ppn;
            ent_perm[fill_slot]  <= fill_perm;
            ent_dirty[fill_slot] <= fill_dirty;
        end
    end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
    parameter int N  = 64,
    parameter int VW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lk_valid,
    input logic [VW-1:0] lk_vpn,
    input logic          lk_hit,
    input logic          lk_miss,
    input logic          walk_busy,
    input logic          fill_valid,
    input logic          base_wr,
    input logic          inv_valid,
    input logic [VW-1:0] inv_vpn,
    input logic [N-1:0]  hit_vec
);
    // R1
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    // R4
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R2
    miss_starts_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_miss && !walk_busy) |=> walk_busy);

    // R3
    fill_ends_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_busy && fill_valid && !base_wr && !inv_valid) |=> !walk_busy);

    // R6
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> !lk_hit);

    // R6
    flush_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr && walk_busy) |=> !walk_busy);

    // R8
    maint_blocks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr || inv_valid) |-> !lk_hit);

    // R7
    inv_removes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid ##1 (lk_valid && lk_vpn == $past(inv_vpn))) |-> !lk_hit);
endmodule

bind tlb_fa tlb_fa_chk #(.N(ENTRIES), .VW(VPN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_vpn     (lk_vpn),
    .lk_hit     (lk_hit),
    .lk_miss    (lk_miss),
    .walk_busy  (walk_busy),
    .fill_valid (fill_valid),
    .base_wr    (base_wr),
    .inv_valid  (inv_valid),
    .inv_vpn    (inv_vpn),
    .hit_vec    (lk_hit_vec)
);

// File: tb/tlb_fa_tb_top.sv
module tlb_fa_tb_top;
    localparam int N  = 4;
    localparam int VW = 5;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          lk_valid;
    logic [VW-1:0] lk_vpn;
    logic          lk_hit, lk_miss, lk_dirty, walk_busy;
    logic [PW-1:0] lk_ppn;
    logic [2:0]    lk_perm;
    logic          fill_valid;
    logic [VW-1:0] fill_vpn;
    logic [PW-1:0] fill_ppn;
    logic [2:0]    fill_perm;
    logic          fill_dirty;
    logic          base_wr;
    logic          inv_valid;
    logic [VW-1:0] inv_vpn;

    always #4 clk = ~clk;

    tlb_fa #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW)) dut_i (.*);

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R1";
    bit    done = 1'b0;
    int    salt = 0;

    // reference model
    bit        m_v   [N];
    int        m_vpn [N];
    int        m_ppn [N];
    int        m_perm[N];
    int        m_d   [N];
    int        m_stamp[N];
    bit        m_busy;
    int        tnow;

    function automatic int ppn_of(int v, int s);
        return (v * 37 + 11 + s * 101) % 256;
    endfunction
    function automatic int perm_of(int v, int s);
        return (v ^ 5 ^ s) % 8;
    endfunction
    function automatic int dirty_of(int v, int s);
        return ((v >> 3) ^ v ^ s) & 1;
    endfunction

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_tag, what, act, exp);
        end
    endtask

    task automatic quiet();
        lk_valid = 0; lk_vpn = '0; fill_valid = 0; fill_vpn = '0; fill_ppn = '0;
        fill_perm = '0; fill_dirty = 0; base_wr = 0; inv_valid = 0; inv_vpn = '0;
    endtask

    // one cycle: compare outputs mid-cycle, then advance the model
    task automatic step();
        int  idx, slot, best;
        bit  found, exp_hit, exp_miss;
        #1;
        found = 0; idx = 0;
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == int'(lk_vpn)) begin found = 1; idx = i; end
        exp_hit  = lk_valid && found && !base_wr && !inv_valid;
        exp_miss = lk_valid && !exp_hit;
        chk("hit", int'(lk_hit), int'(exp_hit));
        chk("miss", int'(lk_miss), int'(exp_miss));
        chk("walk_busy", int'(walk_busy), int'(m_busy));
        if (exp_hit) begin
            chk("ppn", int'(lk_ppn), m_ppn[idx]);
            chk("perm", int'(lk_perm), m_perm[idx]);
            chk("dirty", int'(lk_dirty), m_d[idx]);
        end
        if (base_wr) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
            m_busy = m_busy ? 1'b0 : exp_miss;
        end else if (inv_valid) begin
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_vpn[i] == int'(inv_vpn)) m_v[i] = 0;
            m_busy = m_busy | exp_miss;
        end else if (m_busy && fill_valid) begin
            slot = -1;
            for (int i = 0; i < N; i++)
                if (slot < 0 && m_v[i] && m_vpn[i] == int'(fill_vpn)) slot = i;
            for (int i = 0; i < N; i++)
                if (slot < 0 && !m_v[i]) slot = i;
            if (slot < 0) begin
                best = 0;
                for (int i = 1; i < N; i++)
                    if (m_stamp[i] < m_stamp[best]) best = i;
                slot = best;
            end
            m_v[slot] = 1; m_vpn[slot] = int'(fill_vpn); m_ppn[slot] = int'(fill_ppn);
            m_perm[slot] = int'(fill_perm); m_d[slot] = int'(fill_dirty);
            tnow++; m_stamp[slot] = tnow;
            m_busy = 0;
        end else begin
            if (exp_hit) begin tnow++; m_stamp[idx] = tnow; end
            m_busy = m_busy | exp_miss;
        end
        @(posedge clk);
        @(negedge clk);
        quiet();
    endtask

    task automatic look(int v);
        lk_valid = 1; lk_vpn = VW'(v);
        step();
    endtask

    task automatic set_fill(int v);
        fill_valid = 1; fill_vpn = VW'(v);
        fill_ppn = PW'(ppn_of(v, salt)); fill_perm = 3'(perm_of(v, salt));
        fill_dirty = 1'(dirty_of(v, salt));
    endtask

    task automatic fill(int v);
        set_fill(v);
        step();
    endtask

    task automatic miss_fill(int v);
        look(v);
        fill(v);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        quiet();
        rst_n = 0;
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_stamp[i] = 0; end
        m_busy = 0; tnow = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // reset state: empty, no walk
        cur_tag = "R2"; look(3);          // miss, starts walk
        cur_tag = "R3"; fill(3);          // taken, walk ends
        cur_tag = "R1"; look(3); look(3);

        // R3: refill outside a walk is ignored
        cur_tag = "R3"; fill(9); look(9); fill(9); look(9);

        // R4 / R5: fill to capacity, touch, then evict the LRU entry
        cur_tag = "R4"; miss_fill(1); miss_fill(2);
        cur_tag = "R5"; look(3); look(9);
        cur_tag = "R4"; miss_fill(4);
        look(1); look(2); look(3); look(9); look(4);
        fill(4);
        // duplicate refill overwrites the holder of that page
        salt = 1; look(20); fill(3); look(3); look(20); salt = 0;

        // R7: invalidate one page, others keep hitting
        cur_tag = "R7"; inv_valid = 1; inv_vpn = VW'(3); step();
        look(3); fill(3); look(3); look(9); look(4);

        // R8: maintenance in the same cycle as a lookup
        cur_tag = "R8"; lk_valid = 1; lk_vpn = VW'(9); inv_valid = 1; inv_vpn = VW'(30); step();
        fill(9); look(9);
        lk_valid = 1; lk_vpn = VW'(4); base_wr = 1; step();

        // R9: refill colliding with maintenance is dropped
        cur_tag = "R9"; look(6);
        set_fill(6); inv_valid = 1; inv_vpn = VW'(7); step();
        look(6); fill(6); look(6);
        look(8); set_fill(8); base_wr = 1; step();
        look(8); fill(8); look(8);

        // R6: flush empties and aborts a pending walk
        cur_tag = "R6"; look(12);
        base_wr = 1; step();
        fill(12); look(12); look(6); look(8);

        // sweep over every page, several rounds
        for (int r = 0; r < 6; r++) begin
            salt = r & 1;
            for (int v = 0; v < (1 << VW); v++) begin
                cur_tag = "R4"; look(v);
                cur_tag = "R3"; fill(v);
                cur_tag = "R5"; look((v * 3 + r) % (1 << VW));
                if (v % 7 == 3) begin
                    cur_tag = "R7"; inv_valid = 1; inv_vpn = VW'((v + 31) % (1 << VW)); step();
                end
                if (v % 13 == 5 && r % 2 == 1) begin
                    cur_tag = "R6"; base_wr = 1; step();
                end
                if (v % 5 == 2) begin
                    cur_tag = "R9"; set_fill(v ^ 1); inv_valid = 1; inv_vpn = VW'(v); step();
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule